// File: doc/BRIEF.md
# Resettable Polarity-Selectable Divided Clock

This block turns a fast master clock into a slow square wave. The master clock first passes a fixed prescale (1024 by default). A 3-bit ratio code then picks a further division of 8 raised to the code, so the ratio runs from 1 to 2^21. The output has a 50% duty cycle. Each half-period ends on a terminal count of one shared down-counter.

A polarity bit sets two things together: the active level of the reset pin, and the idle level of the output. Reset only blanks the output. The divider keeps running under it, so pulses that reset suppresses are lost as whole periods and the output phase never moves. After power-on the block holds its output low through a fixed start-up interval, and until the settings are flagged valid. It then releases the output in a way that depends on polarity. A halt input freezes both the divider and the output level.

Top module: `slowclk_gen`

## Requirements
- R1: With ratio code k (0 to 7) and prescale P, each output half-period lasts exactly P/2 × 8^k master cycles, so the output period is P × 8^k cycles with 50% duty.
- R2: While power-on reset is low the output is low. After it is released the output stays low for START_CYCLES master cycles, and longer if the valid flag is still low. With polarity 0 and reset inactive, the first rising edge comes on master edge START_CYCLES+1.
- R3: With polarity 1, the output goes high on the edge that ends start-up. If reset is inactive it falls one master cycle later. If reset is active it stays high.
- R4: With polarity 0, the reset pin is active high. Three master edges after it is asserted, the output is low, and it stays low while reset is held.
- R5: With polarity 1, the reset pin is active low. Three master edges after it is asserted, the output is high, and it stays high while reset is held.
- R6: Reset never moves the divider's phase. After release, the next active output edge falls an exact multiple of the output period after any active edge before the reset.
- R7: A new ratio code takes effect at the next half-period boundary. The half in progress keeps the old length and the next half has the new length, so no half-period is shorter than P/2 master cycles.
- R8: Ratio code and polarity are captured only on cycles where the valid flag is high. Changes made while it is low have no effect on the output.
- R9: Three master edges after halt is asserted, the output holds its level for as long as halt is held. After release, the half-periods resume at the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ratio_sel | input | SEL_W | Ratio code k; the extra division is 8^k |
| pol | input | 1 | Polarity: 0 = reset active high and output idles low, 1 = reset active low and output idles high |
| cfg_valid | input | 1 | Settings-valid flag; ratio_sel and pol are captured while it is high |
| rst_pin | input | 1 | Output reset, asynchronous; its active level is set by pol |
| halt | input | 1 | Asynchronous freeze of divider and output |
| clk_out | output | 1 | Divided clock output |

## Verification
The assertions check the following on every cycle:
- the output stays low before start-up ends;
- an active reset drives the output to the idle level that polarity selects;
- a halted cycle leaves the output unchanged;
- the output changes only at a divider boundary, under reset, or when start-up ends;
- two terminal counts never fall on adjacent cycles.

Only the bench's scenarios can show the rest. These cover the exact half-period lengths for each ratio code, the polarity-dependent start-up shapes, and that pulses released after reset land on the original period grid. They also cover the old-then-new half lengths around a ratio change and the gating by the valid flag.

// File: rtl/slowclk_pkg.sv
`timescale 1ns/1ps
package slowclk_pkg;
    // log2 of the step between adjacent ratio codes (ratio = 8^k)
    localparam int unsigned NDIV_STEP_LOG = 3;

    // Reset pin level that counts as active under a given polarity
    function automatic logic reset_active(input logic polarity, input logic pin);
        return polarity ? ~pin : pin;
    endfunction
endpackage

// File: rtl/slowclk_sync.sv
`timescale 1ns/1ps
module slowclk_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stage_q, stage_d;

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/slowclk_startup.sv
`timescale 1ns/1ps
module slowclk_startup #(
    parameter int unsigned START_CYCLES = 500
) (
    input  logic clk,
    input  logic por_n,
    input  logic cfg_valid,
    output logic run,
    output logic run_next
);
    localparam int unsigned CW = $clog2(START_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(START_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != LAST) st_d.cnt = st_q.cnt + CW'(1);
        if (st_q.cnt == LAST && cfg_valid) st_d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run      = st_q.done;
    assign run_next = st_d.done;

    // R2
    startup_len_chk: assert property (@(posedge clk) disable iff (!por_n)
        st_q.done |-> (st_q.cnt == LAST));
endmodule

// File: rtl/slowclk_divider.sv
`timescale 1ns/1ps
module slowclk_divider #(
    parameter int unsigned PRE_DIV = 1024,
    parameter int unsigned SEL_W   = 3
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             run,
    input  logic             freeze,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int unsigned STEP  = slowclk_pkg::NDIV_STEP_LOG;
    localparam int unsigned BASE  = PRE_DIV / 2;
    localparam int unsigned CNT_W = $clog2(BASE) + STEP * ((1 << SEL_W) - 1) + 1;
    localparam logic [CNT_W-1:0] HALF_MAX = CNT_W'(BASE) << (STEP * ((1 << SEL_W) - 1));

    logic [CNT_W-1:0] cnt_q, cnt_d, reload;

    always_comb begin
        reload = (CNT_W'(BASE) << (STEP * sel)) - CNT_W'(1);
        tick   = run && !freeze && (cnt_q == '0);
        if (!run)       cnt_d = '0;
        else if (freeze) cnt_d = cnt_q;
        else if (tick)  cnt_d = reload;
        else            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7
    min_half_chk: assert property (@(posedge clk) disable iff (!por_n)
        tick |=> !tick);

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!por_n)
        run |-> (cnt_q < HALF_MAX));
endmodule

// File: rtl/slowclk_gen.sv
`timescale 1ns/1ps
module slowclk_gen #(
    parameter int unsigned PRE_DIV      = 1024,
    parameter int unsigned START_CYCLES = 500,
    parameter int unsigned SEL_W        = 3
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic             pol,
    input  logic             cfg_valid,
    input  logic             rst_pin,
    input  logic             halt,
    output logic             clk_out
);
    typedef struct packed {
        logic             pol_cfg;
        logic [SEL_W-1:0] sel_cfg;
        logic             pol_act;
        logic             phase;
        logic             latch;
        logic             out;
    } state_t;

    state_t s_q, s_d;

    logic [1:0] sync_out;
    logic       rst_s, freeze;
    logic       run, run_next, tick, rst_act;

    slowclk_sync #(.W(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .din   ({halt, rst_pin}),
        .dout  (sync_out)
    );
    assign rst_s  = sync_out[0];
    assign freeze = sync_out[1];

    slowclk_startup #(.START_CYCLES(START_CYCLES)) u_startup (
        .clk       (clk),
        .por_n     (por_n),
        .cfg_valid (cfg_valid),
        .run       (run),
        .run_next  (run_next)
    );

    slowclk_divider #(.PRE_DIV(PRE_DIV), .SEL_W(SEL_W)) u_div (
        .clk    (clk),
        .por_n  (por_n),
        .run    (run),
        .freeze (freeze),
        .sel    (s_q.sel_cfg),
        .tick   (tick)
    );

    assign rst_act = slowclk_pkg::reset_active(s_q.pol_act, rst_s);

    always_comb begin
        s_d = s_q;
        if (cfg_valid) begin
            s_d.pol_cfg = pol;
            s_d.sel_cfg = ratio_sel;
        end
        if (run_next && !run) s_d.pol_act = s_d.pol_cfg;
        if (tick) begin
            s_d.pol_act = s_d.pol_cfg;
            s_d.phase   = ~s_q.phase;
        end
        if (!freeze) begin
            if (rst_act)   s_d.latch = 1'b0;
            else if (tick) s_d.latch = s_d.phase;
            s_d.out = run_next ? (s_d.latch ^ s_d.pol_act) : 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign clk_out = s_q.out;

    // R2
    startup_low_chk: assert property (@(posedge clk) disable iff (!por_n)
        !run |-> !clk_out);

    // R4 R5
    rst_force_chk: assert property (@(posedge clk) disable iff (!por_n)
        (run && rst_act && !freeze) |=> (clk_out == s_q.pol_act));

    // R9
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!por_n)
        freeze |=> $stable(clk_out));

    // R6
    out_edge_src_chk: assert property (@(posedge clk) disable iff (!por_n)
        (clk_out != $past(clk_out)) |-> ($past(tick) || $past(rst_act) || $rose(run)));
endmodule

// File: tb/slowclk_gen_test.sv
`timescale 1ns/1ps
module slowclk_gen_test;
    localparam int unsigned PRE   = 8;
    localparam int unsigned START = 40;

    logic       clk = 1'b0;
    logic       por_n, pol, cfg_valid, rst_pin, halt;
    logic [2:0] ratio_sel;
    logic       clk_out;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    int unsigned cyc      = 0;

    slowclk_gen #(.PRE_DIV(PRE), .START_CYCLES(START), .SEL_W(3)) uut (
        .clk       (clk),
        .por_n     (por_n),
        .ratio_sel (ratio_sel),
        .pol       (pol),
        .cfg_valid (cfg_valid),
        .rst_pin   (rst_pin),
        .halt      (halt),
        .clk_out   (clk_out)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int unsigned exp_half(input int unsigned k);
        return (PRE / 2) << (3 * k);
    endfunction

    task automatic check(input bit ok, input string req, input int unsigned act, input int unsigned exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_change(input int unsigned limit, output int unsigned w);
        logic prev;
        prev = clk_out;
        w = 0;
        do begin
            @(negedge clk);
            w++;
        end while (clk_out == prev && w < limit);
    endtask

    task automatic wait_level(input logic lvl);
        int unsigned g;
        g = 0;
        while (clk_out != lvl && g < 5000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic hold_check(input int unsigned n, input logic lvl, input string req);
        int unsigned bad;
        bad = 0;
        repeat (n) begin
            @(negedge clk);
            if (clk_out != lvl) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic power_up(input logic p, input logic rp, input logic v);
        por_n = 1'b0; pol = p; rst_pin = rp; cfg_valid = v; ratio_sel = 3'd0; halt = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(8 * 160000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int unsigned w, w2, t0, t1, c0;
        void'($urandom(32'd1234));

        // R2: reset state, then start-up length with polarity 0
        power_up(1'b0, 1'b0, 1'b1);
        check(clk_out == 1'b0, "R2 output low in power-on reset", clk_out, 0);
        por_n = 1'b1;
        wait_change(5000, w);
        check(w == START + 1, "R2 first rise after start-up", w, START + 1);

        // R1: code 0 half-periods
        wait_change(5000, w);
        check(w == exp_half(0), "R1 half code 0 (high)", w, exp_half(0));
        wait_change(5000, w);
        check(w == exp_half(0), "R1 half code 0 (low)", w, exp_half(0));

        // R7: ratio change, old then new lengths only
        ratio_sel = 3'd1;
        wait_change(5000, w);
        check(w == exp_half(0) || w == exp_half(1), "R7 transitional half", w, exp_half(1));
        wait_change(5000, w);
        check(w == exp_half(1), "R7 new half length", w, exp_half(1));
        wait_change(5000, w);
        check(w == exp_half(1), "R7 new half length repeat", w, exp_half(1));

        // R8: changes with valid low are ignored
        @(negedge clk);
        cfg_valid = 1'b0; ratio_sel = 3'd0; pol = 1'b1;
        wait_change(5000, w);
        wait_change(5000, w);
        check(w == exp_half(1), "R8 ratio unchanged while invalid", w, exp_half(1));
        wait_change(5000, w);
        check(w == exp_half(1), "R8 polarity unchanged while invalid", w, exp_half(1));
        @(negedge clk);
        ratio_sel = 3'd1; pol = 1'b0; cfg_valid = 1'b1;

        // R4 / R6: active-high reset blanks, phase preserved
        wait_level(1'b0);
        wait_level(1'b1);
        t0 = cyc;
        @(negedge clk);
        rst_pin = 1'b1;
        repeat (3) @(negedge clk);
        check(clk_out == 1'b0, "R4 forced low after sync latency", clk_out, 0);
        hold_check(200, 1'b0, "R4 held low under reset");
        rst_pin = 1'b0;
        wait_change(5000, w);
        t1 = cyc;
        check(((t1 - t0) % (2 * exp_half(1))) == 0, "R6 rise on original grid", (t1 - t0) % (2 * exp_half(1)), 0);

        // R9: halt freezes a high level
        @(negedge clk);
        halt = 1'b1;
        hold_check(120, 1'b1, "R9 level frozen under halt");
        halt = 1'b0;
        wait_change(5000, w);
        wait_change(5000, w);
        check(w == exp_half(1), "R9 half length after halt", w, exp_half(1));

        // R1: constrained random ratio codes
        for (int i = 0; i < 6; i++) begin
            int unsigned k;
            k = $urandom_range(0, 3);
            @(negedge clk);
            ratio_sel = 3'(k);
            wait_change(5000, w);
            wait_change(5000, w);
            wait_change(5000, w2);
            check(w2 == exp_half(k), "R1 random code half", w2, exp_half(k));
        end

        // R3: polarity 1, reset inactive
        power_up(1'b1, 1'b1, 1'b1);
        por_n = 1'b1;
        wait_change(5000, w);
        check(w == START, "R3 high at end of start-up", w, START);
        wait_change(5000, w);
        check(w == 1, "R3 single-cycle high", w, 1);
        wait_change(5000, w);
        check(w == exp_half(0), "R1 pol1 active half", w, exp_half(0));

        // R5: active-low reset forces high
        wait_level(1'b0);
        @(negedge clk);
        rst_pin = 1'b0;
        repeat (3) @(negedge clk);
        check(clk_out == 1'b1, "R5 forced high after sync latency", clk_out, 1);
        hold_check(60, 1'b1, "R5 held high under reset");
        rst_pin = 1'b1;

        // R3 / R6: polarity 1 with reset active through start-up
        power_up(1'b1, 1'b0, 1'b1);
        por_n = 1'b1;
        c0 = cyc;
        wait_change(5000, w);
        check(w == START, "R3 high at end of start-up (reset active)", w, START);
        hold_check(100, 1'b1, "R3 stays high while reset active");
        rst_pin = 1'b1;
        wait_change(5000, w);
        t1 = cyc - c0;
        check(((t1 - (START + 1)) % (2 * exp_half(0))) == 0, "R6 fall on start-up grid",
              (t1 - (START + 1)) % (2 * exp_half(0)), 0);

        // R2 / R8: start-up waits for the valid flag
        power_up(1'b0, 1'b0, 1'b0);
        por_n = 1'b1;
        hold_check(START + 60, 1'b0, "R2 low while settings invalid");
        cfg_valid = 1'b1;
        wait_change(5000, w);
        check(w == 2, "R2 first rise after valid", w, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule